// File: doc/BRIEF.md
# Thread-Interleaved Fetch Scheduler

This block is the front end of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) that is shared by as many hardware threads as it has stages. Each cycle it gives the fetch slot to the next thread in a fixed rotation. It issues that thread's program counter, and it tags every stage with the id of the thread that occupies it. A thread therefore holds at most one stage at a time, and it fetches again in the cycle right after its previous instruction leaves writeback. Two consecutive instructions of one thread never overlap, so the pipeline needs no forwarding paths, no interlocks and no hazard detection.

The block holds one program counter per thread. A per-thread stall input turns that thread's slot into a bubble and leaves its program counter as it was. A branch resolved in execute writes the target into the owning thread's counter, and that thread's next slot uses the target. The stage tags drive the register-bank selects: the thread in decode chooses the bank that is read, and the thread in writeback chooses the bank that is written. The pipeline is busy every cycle, and any single thread runs at one instruction per five cycles.

Top module: `tip_sched`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the slot belongs to thread 0 and stages 1 to 4 hold no valid instruction. The first slot of thread t shows the program counter RESET_BASE + t*RESET_STRIDE.
- R2: The fetch slot owner goes 0, 1, 2, 3, 4 and then back to 0, one step per cycle, whatever the stall and branch inputs do. Thread 0 owns the first cycle after reset.
- R3: An instruction that issues without a stall and without a branch advances its thread's program counter by 4. The next slot of that thread shows the old value plus 4.
- R4: When stall_req bit t is high during thread t's slot, fetch_valid is 0 and thread t's counter keeps its value. Every other thread keeps its slot and its counter.
- R5: A branch report (br_valid, br_tid, br_target) made while thread br_tid is in execute (stage 2) sets that thread's counter to br_target. The thread's next slot fetches from br_target.
- R6: Stage k (index 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback) carries the valid bit and the thread id that stage k-1 carried one cycle earlier. stage_tid packs the thread id of stage k at bits [k*3 +: 3].
- R7: No thread has more than one valid instruction across the five stages.
- R8: rd_bank_sel is the one-hot code of the decode-stage thread when that stage is valid, and zero otherwise. wr_bank_en is the same code taken from the writeback stage.
- R9: When the writeback stage holds a thread, the next cycle's fetch slot belongs to that same thread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_req | input | 5 | Per-thread stall, bit t for thread t |
| br_valid | input | 1 | A branch resolved in execute this cycle |
| br_tid | input | 3 | Thread that owns the branch |
| br_target | input | 32 | Branch target address |
| fetch_valid | output | 1 | The fetch slot issues a real instruction (0 = bubble) |
| fetch_tid | output | 3 | Thread that owns this cycle's fetch slot |
| fetch_pc | output | 32 | Program counter fetched in this slot |
| stage_vld | output | 5 | Valid bit per stage, bit 0 = fetch |
| stage_tid | output | 15 | Thread id per stage, 3 bits each, stage 0 lowest |
| rd_bank_sel | output | 5 | One-hot register bank read by the decode stage |
| wr_bank_en | output | 5 | One-hot register bank written by the writeback stage |

## Verification
The assertions take for granted that a branch is reported only for the thread that sits in a valid execute stage, and that at most one branch is reported per cycle. The checker states this as its own property. The bench builds its branch stimulus only from its model's record of the thread in execute, and it chooses the target at random with the low two bits clear. Stall requests are random per thread and never touch that rule. The directed phases cover a single thread stalled, every thread stalled, and a branch on every possible cycle.

// File: rtl/tip_pkg.sv
`timescale 1ns/1ps
// Shared constants for the thread-interleaved scheduler.
// Assumes a five-stage in-order pipeline with one stage per cycle.
package tip_pkg;
    localparam int NUM_STAGES = 5;

    // Stage indices as used by the stage tag outputs.
    typedef enum int {
        STG_IF  = 0,
        STG_ID  = 1,
        STG_EX  = 2,
        STG_MEM = 3,
        STG_WB  = 4
    } stage_e;
endpackage

// File: rtl/tip_slot_rotor.sv
`timescale 1ns/1ps
// Slot rotor: modulo-N_THREADS counter that names the thread owning the
// fetch slot. Assumes nothing about stalls; the rotation never pauses.
module tip_slot_rotor #(
    parameter int N_THREADS = 5,
    parameter int TID_W     = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [TID_W-1:0] slot_tid
);
    localparam logic [TID_W-1:0] LAST_TID = TID_W'(N_THREADS - 1);

    // Advance to the next thread every cycle, wrapping after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_tid <= '0;
        else if (slot_tid == LAST_TID)
            slot_tid <= '0;
        else
            slot_tid <= slot_tid + 1'b1;
    end
endmodule

// File: rtl/tip_pc_bank.sv
`timescale 1ns/1ps
// Per-thread program counter bank. Reads the counter of the slot owner,
// steps it when that slot issues, and loads a branch target for the
// thread reporting a branch. Assumes the branch thread differs from the
// slot owner (a branch comes from execute, two slots behind fetch).
module tip_pc_bank #(
    parameter int              N_THREADS    = 5,
    parameter int              TID_W        = 3,
    parameter int              PC_W         = 32,
    parameter logic [PC_W-1:0] RESET_BASE   = 32'h0000_1000,
    parameter logic [PC_W-1:0] RESET_STRIDE = 32'h0000_0100,
    parameter logic [PC_W-1:0] PC_STEP      = 32'd4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TID_W-1:0] rd_tid,
    input  logic             adv,
    input  logic             br_valid,
    input  logic [TID_W-1:0] br_tid,
    input  logic [PC_W-1:0]  br_target,
    output logic [PC_W-1:0]  rd_pc
);
    logic [PC_W-1:0] pc_all [N_THREADS];

    for (genvar t = 0; t < N_THREADS; t++) begin : g_thr
        localparam logic [PC_W-1:0] PC_RST = RESET_BASE + PC_W'(t) * RESET_STRIDE;
        logic [PC_W-1:0] pc_r;

        // Hold this thread's counter: branch load first, else step on issue.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pc_r <= PC_RST;
            else if (br_valid && br_tid == TID_W'(t))
                pc_r <= br_target;
            else if (adv && rd_tid == TID_W'(t))
                pc_r <= pc_r + PC_STEP;
        end

        assign pc_all[t] = pc_r;
    end

    assign rd_pc = pc_all[rd_tid];
endmodule

// File: rtl/tip_tag_pipe.sv
`timescale 1ns/1ps
// Stage tag pipeline: carries the valid bit and thread id of each slot
// from fetch down to writeback, one stage per cycle. Bubbles keep their
// thread id so every stage always names the slot owner.
module tip_tag_pipe #(
    parameter int N_STG = 5,
    parameter int TID_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [TID_W-1:0]            in_tid,
    output logic [N_STG-1:1]            vld_q,
    output logic [N_STG-1:1][TID_W-1:0] tid_q
);
    // Shift the tags one stage per cycle; reset clears every stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            tid_q <= '0;
        end else begin
            vld_q[1] <= in_vld;
            tid_q[1] <= in_tid;
            for (int k = 2; k < N_STG; k++) begin
                vld_q[k] <= vld_q[k-1];
                tid_q[k] <= tid_q[k-1];
            end
        end
    end
endmodule

// File: rtl/tip_sched.sv
`timescale 1ns/1ps
// Thread-interleaved fetch scheduler (top). Gives the fetch slot to one
// thread per cycle in strict rotation, issues its program counter unless
// it is stalled, tags every stage with its thread, and decodes the
// register bank selects. Assumes N_THREADS equals the stage count, so a
// thread never has two instructions in flight; no hazard logic exists.
module tip_sched
    import tip_pkg::*;
#(
    parameter int              N_THREADS    = NUM_STAGES,
    parameter int              PC_W         = 32,
    parameter logic [PC_W-1:0] RESET_BASE   = 32'h0000_1000,
    parameter logic [PC_W-1:0] RESET_STRIDE = 32'h0000_0100,
    localparam int             TID_W        = $clog2(N_THREADS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_THREADS-1:0]       stall_req,
    input  logic                       br_valid,
    input  logic [TID_W-1:0]           br_tid,
    input  logic [PC_W-1:0]            br_target,
    output logic                       fetch_valid,
    output logic [TID_W-1:0]           fetch_tid,
    output logic [PC_W-1:0]            fetch_pc,
    output logic [N_THREADS-1:0]       stage_vld,
    output logic [N_THREADS*TID_W-1:0] stage_tid,
    output logic [N_THREADS-1:0]       rd_bank_sel,
    output logic [N_THREADS-1:0]       wr_bank_en
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

    logic [N_THREADS-1:1]            pipe_vld;
    logic [N_THREADS-1:1][TID_W-1:0] pipe_tid;

    tip_slot_rotor #(
        .N_THREADS(N_THREADS),
        .TID_W    (TID_W)
    ) u_rotor (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_tid(fetch_tid)
    );

    // A slot issues unless its owner asks for a stall.
    always_comb fetch_valid = !stall_req[fetch_tid];

    tip_pc_bank #(
        .N_THREADS   (N_THREADS),
        .TID_W       (TID_W),
        .PC_W        (PC_W),
        .RESET_BASE  (RESET_BASE),
        .RESET_STRIDE(RESET_STRIDE),
        .PC_STEP     (PC_STEP)
    ) u_pcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_tid   (fetch_tid),
        .adv      (fetch_valid),
        .br_valid (br_valid),
        .br_tid   (br_tid),
        .br_target(br_target),
        .rd_pc    (fetch_pc)
    );

    tip_tag_pipe #(
        .N_STG(N_THREADS),
        .TID_W(TID_W)
    ) u_tags (
        .clk   (clk),
        .rst_n (rst_n),
        .in_vld(fetch_valid),
        .in_tid(fetch_tid),
        .vld_q (pipe_vld),
        .tid_q (pipe_tid)
    );

    assign stage_vld = {pipe_vld, fetch_valid};
    assign stage_tid = {pipe_tid, fetch_tid};

    // Decode the read bank from decode and the write bank from writeback.
    always_comb begin
        rd_bank_sel = '0;
        wr_bank_en  = '0;
        for (int t = 0; t < N_THREADS; t++) begin
            rd_bank_sel[t] = pipe_vld[STG_ID] && (pipe_tid[STG_ID] == TID_W'(t));
            wr_bank_en[t]  = pipe_vld[STG_WB] && (pipe_tid[STG_WB] == TID_W'(t));
        end
    end
endmodule

// File: rtl/tip_sched_chk.sv
`timescale 1ns/1ps
// Property checker for tip_sched, attached by bind. Relates the slot
// rotation, stall bubbles, stage tags and bank selects over time.
module tip_sched_chk #(
    parameter int N_THREADS = 5,
    parameter int TID_W     = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [N_THREADS-1:0]       stall_req,
    input logic                       br_valid,
    input logic [TID_W-1:0]           br_tid,
    input logic                       fetch_valid,
    input logic [TID_W-1:0]           fetch_tid,
    input logic [N_THREADS-1:0]       stage_vld,
    input logic [N_THREADS*TID_W-1:0] stage_tid,
    input logic [N_THREADS-1:0]       rd_bank_sel,
    input logic [N_THREADS-1:0]       wr_bank_en
);
    localparam logic [TID_W-1:0] LAST_TID = TID_W'(N_THREADS - 1);
    localparam int               WB       = N_THREADS - 1;

    logic [TID_W-1:0] tid_at [N_THREADS];
    for (genvar k = 0; k < N_THREADS; k++) begin : g_unpack
        assign tid_at[k] = stage_tid[k*TID_W +: TID_W];
    end

    // R2: the slot owner steps by one each cycle and wraps.
    p_rotate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> fetch_tid == (($past(fetch_tid) == LAST_TID) ? '0 : $past(fetch_tid) + 1'b1));

    // R4: a stalled owner gets a bubble, an unstalled owner issues.
    p_stall_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req[fetch_tid] |-> !fetch_valid);
    p_nostall_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_req[fetch_tid] |-> fetch_valid);

    // R5 (input rule): a branch comes only from the valid execute stage's thread.
    p_br_in_exec_r5: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |-> (stage_vld[2] && tid_at[2] == br_tid));

    // R6: each stage takes the previous stage's tag one cycle later.
    for (genvar k = 1; k < N_THREADS; k++) begin : g_shift
        p_tag_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (stage_vld[k] == $past(stage_vld[k-1])) && (tid_at[k] == $past(tid_at[k-1])));
    end

    // R7: at most one valid instruction per thread across all stages.
    for (genvar t = 0; t < N_THREADS; t++) begin : g_one
        logic [N_THREADS-1:0] hit;
        for (genvar k = 0; k < N_THREADS; k++) begin : g_hit
            assign hit[k] = stage_vld[k] && (tid_at[k] == TID_W'(t));
        end
        p_one_inflight_r7: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(hit) <= 1);
    end

    // R8: bank selects are one-hot and point at the decode / writeback thread.
    p_rd_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_bank_sel) && (rd_bank_sel[tid_at[1]] == stage_vld[1]));
    p_wr_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_bank_en) && (wr_bank_en[tid_at[WB]] == stage_vld[WB]));

    // R9: a thread leaving writeback owns the next fetch slot.
    p_refetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stage_vld[WB] |=> fetch_tid == $past(tid_at[WB]));
endmodule

bind tip_sched tip_sched_chk #(
    .N_THREADS(N_THREADS),
    .TID_W    (TID_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_req  (stall_req),
    .br_valid   (br_valid),
    .br_tid     (br_tid),
    .fetch_valid(fetch_valid),
    .fetch_tid  (fetch_tid),
    .stage_vld  (stage_vld),
    .stage_tid  (stage_tid),
    .rd_bank_sel(rd_bank_sel),
    .wr_bank_en (wr_bank_en)
);

// File: tb/tb_tip_sched.sv
`timescale 1ns/1ps
module tb_tip_sched;
    localparam int          NT     = 5;
    localparam int          TW     = 3;
    localparam logic [31:0] BASE   = 32'h0000_1000;
    localparam logic [31:0] STRIDE = 32'h0000_0100;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NT-1:0]  stall_req = '0;
    logic           br_valid = 1'b0;
    logic [TW-1:0]  br_tid = '0;
    logic [31:0]    br_target = '0;
    logic           fetch_valid;
    logic [TW-1:0]  fetch_tid;
    logic [31:0]    fetch_pc;
    logic [NT-1:0]  stage_vld;
    logic [NT*TW-1:0] stage_tid;
    logic [NT-1:0]  rd_bank_sel;
    logic [NT-1:0]  wr_bank_en;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state
    logic [31:0] mpc [NT];
    string       why [NT];
    bit          mv  [NT];
    int          mt  [NT];
    bit          prev_wb_v;
    int          prev_wb_t;

    tip_sched #(.N_THREADS(NT), .PC_W(32), .RESET_BASE(BASE), .RESET_STRIDE(STRIDE)) dut (
        .clk(clk), .rst_n(rst_n), .stall_req(stall_req), .br_valid(br_valid),
        .br_tid(br_tid), .br_target(br_target), .fetch_valid(fetch_valid),
        .fetch_tid(fetch_tid), .fetch_pc(fetch_pc), .stage_vld(stage_vld),
        .stage_tid(stage_tid), .rd_bank_sel(rd_bank_sel), .wr_bank_en(wr_bank_en));

    always #4 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [NT-1:0] onehot_of(input bit v, input int t);
        return v ? (NT'(1) << t) : '0;
    endfunction

    function automatic int next_tid(input int t);
        return (t == NT - 1) ? 0 : t + 1;
    endfunction

    function automatic logic [TW-1:0] port_tid(input int k);
        return stage_tid[k*TW +: TW];
    endfunction

    task automatic model_reset();
        for (int t = 0; t < NT; t++) begin
            mpc[t] = BASE + 32'(t) * STRIDE;
            why[t] = "R1";
            mv[t]  = 1'b0;
            mt[t]  = 0;
        end
        prev_wb_v = 1'b0;
        prev_wb_t = 0;
    endtask

    // Apply reset, check the reset state, release so the next window is cycle 0.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; stall_req = '0; br_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", "stage_vld in reset", 64'(stage_vld[NT-1:1]), 64'(0));
        chk("R1", "fetch_tid in reset", 64'(fetch_tid), 64'(0));
        chk("R1", "fetch_pc in reset", 64'(fetch_pc), 64'(BASE));
        @(posedge clk);
        #1 rst_n = 1'b1;
        model_reset();
    endtask

    // One cycle: drive, check against the model, then advance the model.
    task automatic step(input logic [NT-1:0] stl, input bit want_br);
        bit          ev;
        bit          did_br;
        int          bt;
        logic [31:0] tgt;
        int          cnt;
        @(negedge clk);
        stall_req = stl;
        did_br = want_br && mv[2];
        bt  = mt[2];
        tgt = $urandom & 32'hFFFF_FFFC;
        br_valid  = did_br;
        br_tid    = TW'(bt);
        br_target = tgt;
        #1;
        ev = !stl[mt[0]];
        mv[0] = ev;
        chk("R2", "fetch_tid", 64'(fetch_tid), 64'(mt[0]));
        chk("R4", "fetch_valid", 64'(fetch_valid), 64'(ev));
        chk(why[mt[0]], "fetch_pc", 64'(fetch_pc), 64'(mpc[mt[0]]));
        for (int k = 1; k < NT; k++) begin
            chk("R6", $sformatf("stage_vld[%0d]", k), 64'(stage_vld[k]), 64'(mv[k]));
            chk("R6", $sformatf("stage_tid[%0d]", k), 64'(port_tid(k)), 64'(mt[k]));
        end
        chk("R8", "rd_bank_sel", 64'(rd_bank_sel), 64'(onehot_of(mv[1], mt[1])));
        chk("R8", "wr_bank_en", 64'(wr_bank_en), 64'(onehot_of(mv[NT-1], mt[NT-1])));
        if (prev_wb_v)
            chk("R9", "refetch after writeback", 64'(fetch_tid), 64'(prev_wb_t));
        for (int t = 0; t < NT; t++) begin
            cnt = 0;
            for (int k = 0; k < NT; k++)
                if (stage_vld[k] && port_tid(k) == TW'(t)) cnt++;
            chk("R7", $sformatf("inflight count thread %0d <= 1", t), 64'(cnt > 1), 64'(0));
        end
        // Advance the model by one clock edge.
        if (ev) begin
            mpc[mt[0]] = mpc[mt[0]] + 32'd4;
            why[mt[0]] = "R3";
        end else begin
            why[mt[0]] = "R4";
        end
        if (did_br) begin
            mpc[bt] = tgt;
            why[bt] = "R5";
        end
        prev_wb_v = mv[NT-1];
        prev_wb_t = mt[NT-1];
        for (int k = NT - 1; k >= 1; k--) begin
            mv[k] = mv[k-1];
            mt[k] = mt[k-1];
        end
        mt[0] = next_tid(mt[0]);
    endtask

    function automatic logic [NT-1:0] rand_stall(input int pct);
        logic [NT-1:0] s = '0;
        for (int t = 0; t < NT; t++)
            s[t] = (($urandom % 100) < pct);
        return s;
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R3: free running, sequential fetch only
        for (int i = 0; i < 40; i++) step('0, 1'b0);
        // R4: only thread 2 stalled, others unaffected
        for (int i = 0; i < 15; i++) step(NT'(1) << 2, 1'b0);
        // R4: every thread stalled, pipeline drains to bubbles
        for (int i = 0; i < 10; i++) step('1, 1'b0);
        // R5: branch on every cycle an execute stage holds a thread
        for (int i = 0; i < 25; i++) step('0, 1'b1);
        // R1: reset in mid-run
        do_reset();
        // Mixed random traffic
        for (int i = 0; i < 2000; i++) step(rand_stall(25), (($urandom % 3) == 0));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule